// File: doc/BRIEF.md
# Single-Channel Register-Programmed DMA Engine

This block is one DMA channel. Software sets it up through four 32-bit registers: a source address, a destination address, a cycle count and a control word. When the enable bit is set, the channel copies data one unit at a time. Each unit is read from the source address over a simple valid/ready master port and then written to the destination address. After every unit, each address moves by its own signed step.

One transfer cycle is either a single unit or, in burst mode, a group of four units. The cycle count goes down by one as each cycle completes. Software can read the count at any time to see how much work remains. Either address may be tied to a peripheral request line. When it is, every cycle waits for that request, and the channel answers with a one-cycle grant once the cycle's last write is accepted.

When the count reaches zero, the finish status is set. An error response on the master port sets the error status instead. Both events stop the channel, and each can raise the interrupt output if its enable bit is set.

Top module: `dmac_chan`

## Requirements
- R1: After reset, all four registers read 0, `m_valid` is 0, `irq` is 0 and `dgnt` is 0.
- R2: Byte offsets are decoded from `reg_addr[3:2]`: 0 is the source address, 4 the destination address, 8 the cycle count and 12 control. A read returns its data in `reg_rdata` one clock after `reg_rd`. Unassigned control bits (11, 15, 23:22, 31:28) always read 0.
- R3: Each unit is read from the source address and then written unchanged to the destination address. When the last cycle completes, control bit 1 (finish) is set and bit 0 (enable) clears. Enabling with a count of 0 finishes at once with no master access.
- R4: The source step code is in control bits 10:8 and the destination step code in bits 14:12. Each address moves after every unit by a signed byte amount: 000→0, 001→+1, 010→+2, 011→+4, 101→−1, 110→−2, 111→−4. Code 100 means 0.
- R5: Control bit 3 selects burst mode. In burst mode one cycle is four units, so over one cycle each address moves by four times its step.
- R6: Control bits 21:20 set the data width shown on `m_size` (00 word, 01 halfword, 10 byte). `m_sys` shows control bit 6 during reads and control bit 7 during writes.
- R7: The destination request line number is in bits 19:16 and the source line number in bits 27:24. A value of 0 means the cycle does not wait on that side. A nonzero value N makes each cycle wait for `dreq[N]`. The clock after the cycle's last accepted write, `dgnt[N]` pulses high for one clock.
- R8: `irq` equals (bit 1 AND bit 2) OR (bit 4 AND bit 5) of the previous clock.
- R9: An error response during a read or a write sets control bit 4 (error) and clears enable. The unit is abandoned, the count is not decremented and the destination address does not move.
- R10: Writing 0 to a status bit (1 or 4) clears it. Writing 1 to a status bit leaves it unchanged.
- R11: The count register holds 24 bits, drops by exactly one per completed cycle, and reads back the live remaining count while a transfer is running.
- R12: While `m_valid` is high and `m_ready` is low, the address and direction on the master port hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| m_valid | output | 1 | Master request valid |
| m_write | output | 1 | 1 = write, 0 = read |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Write data |
| m_size | output | 2 | Unit width code |
| m_sys | output | 1 | Selected bus for this access (1 = system bus) |
| m_rdata | input | 32 | Read data |
| m_ready | input | 1 | Access accepted |
| m_err | input | 1 | Error response, valid with m_ready |
| dreq | input | 16 | Peripheral request lines |
| dgnt | output | 16 | Peripheral grant pulses |
| irq | output | 1 | Interrupt |

## Verification
Master writes are accepted at the clock edge on which `m_ready` is high. The scoreboard monitor therefore compares each write at the falling edge inside that handshake cycle. A register read is due one clock after its strobe, so the bench samples `reg_rdata` at the next falling edge. `irq` follows a status change by one further clock, and the bench samples it only after that clock has passed. A grant appears on the clock after the final write of a cycle. The bench counts grants and accepted writes at falling edges, and compares those totals and the live count only after several idle clocks, so no check depends on the exact edge where the engine pauses for a request.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int CB_EN      = 0;
  localparam int CB_FIN     = 1;
  localparam int CB_FIN_IE  = 2;
  localparam int CB_BURST   = 3;
  localparam int CB_ERR     = 4;
  localparam int CB_ERR_IE  = 5;
  localparam int CB_SRC_SYS = 6;
  localparam int CB_DST_SYS = 7;
  localparam logic [31:0] CTRL_WMASK = 32'h0F3F_77FF;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_READ, ST_WRITE} xfer_state_t;

  function automatic logic signed [3:0] step_of(input logic [2:0] code);
    case (code)
      3'b001:  step_of = 4'sd1;
      3'b010:  step_of = 4'sd2;
      3'b011:  step_of = 4'sd4;
      3'b101:  step_of = -4'sd1;
      3'b110:  step_of = -4'sd2;
      3'b111:  step_of = -4'sd4;
      default: step_of = 4'sd0;
    endcase
  endfunction
endpackage

// File: rtl/dmac_addr_step.sv
module dmac_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    code,
  output logic [AW-1:0] next
);
  logic signed [3:0] delta;
  always_comb begin
    delta = dmac_pkg::step_of(code);
    next  = addr + {{(AW-4){delta[3]}}, delta};
  end
endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [1:0]    idx,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          src_adv,
  input  logic [AW-1:0] src_next,
  input  logic          dst_adv,
  input  logic [AW-1:0] dst_next,
  input  logic          cnt_dec,
  input  logic          fin_set,
  input  logic          err_set,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic [CW-1:0] cnt,
  output logic [31:0]   ctrl
);
  logic [31:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl;
    if (wr && idx == 2'd3) begin
      ctrl_d         = wdata & CTRL_WMASK;
      ctrl_d[CB_FIN] = ctrl[CB_FIN] & wdata[CB_FIN];
      ctrl_d[CB_ERR] = ctrl[CB_ERR] & wdata[CB_ERR];
    end
    if (fin_set) begin
      ctrl_d[CB_FIN] = 1'b1;
      ctrl_d[CB_EN]  = 1'b0;
    end
    if (err_set) begin
      ctrl_d[CB_ERR] = 1'b1;
      ctrl_d[CB_EN]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src   <= '0;
      dst   <= '0;
      cnt   <= '0;
      ctrl  <= '0;
      rdata <= '0;
    end else begin
      ctrl <= ctrl_d;
      if (wr && idx == 2'd0)      src <= wdata[AW-1:0];
      else if (src_adv)           src <= src_next;
      if (wr && idx == 2'd1)      dst <= wdata[AW-1:0];
      else if (dst_adv)           dst <= dst_next;
      if (wr && idx == 2'd2)      cnt <= wdata[CW-1:0];
      else if (cnt_dec)           cnt <= cnt - 1'b1;
      if (rd) begin
        case (idx)
          2'd0:    rdata <= 32'(src);
          2'd1:    rdata <= 32'(dst);
          2'd2:    rdata <= 32'(cnt);
          default: rdata <= ctrl;
        endcase
      end
    end
  end
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer
  import dmac_pkg::*;
#(
  parameter int CW     = 24,
  parameter int LINE_W = 4,
  localparam int NLINES = 1 << LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              burst,
  input  logic [LINE_W-1:0] src_line,
  input  logic [LINE_W-1:0] dst_line,
  input  logic [CW-1:0]     cnt,
  input  logic [NLINES-1:0] dreq,
  input  logic              m_ready,
  input  logic              m_err,
  input  logic [31:0]       m_rdata,
  output logic              m_valid,
  output logic              m_write,
  output logic [31:0]       m_wdata,
  output logic              src_adv,
  output logic              dst_adv,
  output logic              cnt_dec,
  output logic              fin_set,
  output logic              err_set,
  output logic [NLINES-1:0] dgnt
);
  xfer_state_t st;
  logic [1:0]  unit;
  logic        last_unit, lines_ok, cnt_last;

  always_comb begin
    m_valid   = (st == ST_READ) || (st == ST_WRITE);
    m_write   = (st == ST_WRITE);
    last_unit = !burst || (unit == 2'd3);
    cnt_last  = (cnt == CW'(1));
    lines_ok  = (src_line == '0 || dreq[src_line]) &&
                (dst_line == '0 || dreq[dst_line]);
    src_adv   = (st == ST_READ)  && m_ready && !m_err;
    dst_adv   = (st == ST_WRITE) && m_ready && !m_err;
    cnt_dec   = dst_adv && last_unit;
    err_set   = m_valid && m_ready && m_err;
    fin_set   = (cnt_dec && cnt_last) ||
                ((st == ST_IDLE) && en && cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      unit    <= '0;
      m_wdata <= '0;
      dgnt    <= '0;
    end else begin
      dgnt <= '0;
      case (st)
        ST_IDLE: if (en && cnt != '0) st <= ST_WAIT;
        ST_WAIT: begin
          if (!en) st <= ST_IDLE;
          else if (lines_ok) begin
            st   <= ST_READ;
            unit <= '0;
          end
        end
        ST_READ: if (m_ready) begin
          if (m_err) st <= ST_IDLE;
          else begin
            m_wdata <= m_rdata;
            st      <= ST_WRITE;
          end
        end
        default: if (m_ready) begin
          if (m_err) st <= ST_IDLE;
          else if (last_unit) begin
            st <= cnt_last ? ST_IDLE : ST_WAIT;
            if (src_line != '0) dgnt[src_line] <= 1'b1;
            if (dst_line != '0) dgnt[dst_line] <= 1'b1;
          end else begin
            unit <= unit + 1'b1;
            st   <= ST_READ;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan
  import dmac_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 24,
  parameter int LINE_W = 4,
  localparam int NLINES = 1 << LINE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_valid,
  output logic              m_write,
  output logic [AW-1:0]     m_addr,
  output logic [31:0]       m_wdata,
  output logic [1:0]        m_size,
  output logic              m_sys,
  input  logic [31:0]       m_rdata,
  input  logic              m_ready,
  input  logic              m_err,
  input  logic [NLINES-1:0] dreq,
  output logic [NLINES-1:0] dgnt,
  output logic              irq
);
  logic [AW-1:0] src, dst;
  logic [CW-1:0] cnt;
  logic [31:0]   ctrl;
  logic          src_adv, dst_adv, cnt_dec, fin_set, err_set;
  logic [AW-1:0] cur_addr [2];
  logic [AW-1:0] nxt_addr [2];
  logic [2:0]    step_code [2];

  assign cur_addr[0]  = src;
  assign cur_addr[1]  = dst;
  assign step_code[0] = ctrl[10:8];
  assign step_code[1] = ctrl[14:12];

  for (genvar g = 0; g < 2; g++) begin : g_step
    dmac_addr_step #(.AW(AW)) step_i (
      .addr(cur_addr[g]), .code(step_code[g]), .next(nxt_addr[g]));
  end

  dmac_regs #(.AW(AW), .CW(CW)) regs_i (
    .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .idx(reg_addr[3:2]),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .src_adv(src_adv), .src_next(nxt_addr[0]),
    .dst_adv(dst_adv), .dst_next(nxt_addr[1]),
    .cnt_dec(cnt_dec), .fin_set(fin_set), .err_set(err_set),
    .src(src), .dst(dst), .cnt(cnt), .ctrl(ctrl));

  dmac_xfer #(.CW(CW), .LINE_W(LINE_W)) xfer_i (
    .clk(clk), .rst(rst), .en(ctrl[CB_EN]), .burst(ctrl[CB_BURST]),
    .src_line(ctrl[24 +: LINE_W]), .dst_line(ctrl[16 +: LINE_W]),
    .cnt(cnt), .dreq(dreq), .m_ready(m_ready), .m_err(m_err),
    .m_rdata(m_rdata), .m_valid(m_valid), .m_write(m_write),
    .m_wdata(m_wdata), .src_adv(src_adv), .dst_adv(dst_adv),
    .cnt_dec(cnt_dec), .fin_set(fin_set), .err_set(err_set), .dgnt(dgnt));

  always_comb begin
    m_addr = m_write ? dst : src;
    m_size = ctrl[21:20];
    m_sys  = m_write ? ctrl[CB_DST_SYS] : ctrl[CB_SRC_SYS];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (ctrl[CB_FIN] & ctrl[CB_FIN_IE]) |
                    (ctrl[CB_ERR] & ctrl[CB_ERR_IE]);
  end
endmodule

// File: rtl/dmac_chan_chk.sv
module dmac_chan_chk #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int NLINES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        reg_addr,
  input logic              reg_wr,
  input logic [31:0]       ctrl,
  input logic [CW-1:0]     cnt,
  input logic              m_valid,
  input logic              m_write,
  input logic              m_ready,
  input logic [AW-1:0]     m_addr,
  input logic [NLINES-1:0] dgnt,
  input logic              irq
);
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (rst)
    irq == $past((ctrl[1] & ctrl[2]) | (ctrl[4] & ctrl[5])));

  p_fin_stops_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl[1]) |-> !ctrl[0]);

  p_err_stops_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl[4]) |-> !ctrl[0]);

  p_cnt_step_r11: assert property (@(posedge clk) disable iff (rst)
    (!$past(reg_wr && reg_addr[3:2] == 2'd2) && cnt != $past(cnt))
      |-> cnt == CW'($past(cnt) - 1'b1));

  p_gnt_after_write_r7: assert property (@(posedge clk) disable iff (rst)
    (dgnt != '0) |-> $past(m_valid && m_write && m_ready));

  p_gnt_line0_r7: assert property (@(posedge clk) disable iff (rst)
    !dgnt[0] && $countones(dgnt) <= 2);

  p_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready && !reg_wr) |=>
      (m_valid && $stable(m_addr) && $stable(m_write)));
endmodule

bind dmac_chan dmac_chan_chk #(.AW(AW), .CW(CW), .NLINES(NLINES)) chk_i (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .ctrl(ctrl), .cnt(cnt), .m_valid(m_valid), .m_write(m_write),
  .m_ready(m_ready), .m_addr(m_addr), .dgnt(dgnt), .irq(irq));

// File: tb/dmac_chan_tb_top.sv
`timescale 1ns/1ps
module dmac_chan_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        m_valid, m_write, m_sys, m_ready, m_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0]  m_size;
  logic [15:0] dreq = '0, dgnt;
  logic        irq;
  logic        stall = 1'b0, stall_en = 1'b0, err_on = 1'b0;
  logic [31:0] err_addr = '0;

  dmac_chan dut_i (.clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_size(m_size), .m_sys(m_sys), .m_rdata(m_rdata), .m_ready(m_ready),
    .m_err(m_err), .dreq(dreq), .dgnt(dgnt), .irq(irq));

  function automatic logic [31:0] mem_fn(input logic [31:0] a);
    return {a[15:0], ~a[15:0]};
  endfunction
  function automatic int step_b(input logic [2:0] c);
    case (c)
      3'b001: return 1;  3'b010: return 2;  3'b011: return 4;
      3'b101: return -1; 3'b110: return -2; 3'b111: return -4;
      default: return 0;
    endcase
  endfunction

  assign m_rdata = mem_fn(m_addr);
  assign m_ready = m_valid & ~stall;
  assign m_err   = m_valid & err_on & (m_addr == err_addr);
  always @(negedge clk) if (stall_en) stall <= ~stall; else stall <= 1'b0;

  int vectors = 0, fails = 0, writes_seen = 0, gnt3 = 0, gnt_other = 0;
  logic [31:0] q_addr[$], q_data[$];
  logic [2:0]  q_meta[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compare each accepted write against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && m_valid && m_ready && m_write && !m_err) begin
      writes_seen++;
      if (q_addr.size() == 0) check(1'b0, "R3 unexpected write", m_addr, 32'h0);
      else begin
        logic [31:0] ea, ed; logic [2:0] em;
        ea = q_addr.pop_front(); ed = q_data.pop_front(); em = q_meta.pop_front();
        check(m_addr == ea, "R4 write address", m_addr, ea);
        check(m_wdata == ed, "R3 write data", m_wdata, ed);
        check({m_sys, m_size} == em, "R6 size/bus", {29'h0, m_sys, m_size}, {29'h0, em});
      end
    end
    if (!rst) begin
      if (dgnt[3]) gnt3++;
      if ((dgnt & ~16'h0008) != '0) gnt_other++;
    end
  end

  // driver: push the expected writes of a transfer
  task automatic push_xfer(input logic [31:0] s, input logic [31:0] d, input logic [2:0] sc,
                           input logic [2:0] dc, input int units, input logic [2:0] meta);
    for (int k = 0; k < units; k++) begin
      q_addr.push_back(d + 32'(k * step_b(dc)));
      q_data.push_back(mem_fn(s + 32'(k * step_b(sc))));
      q_meta.push_back(meta);
    end
  endtask

  task automatic reg_write(input int idx, input logic [31:0] v);
    @(negedge clk); reg_addr = 4'(idx * 4); reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask
  task automatic reg_read(input int idx, output logic [31:0] v);
    @(negedge clk); reg_addr = 4'(idx * 4); reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
  endtask
  task automatic expect_reg(input int idx, input logic [31:0] e, input string tag);
    logic [31:0] v;
    reg_read(idx, v);
    check(v === e, tag, v, e);
  endtask
  task automatic setup(input logic [31:0] s, input logic [31:0] d, input logic [31:0] n);
    reg_write(0, s); reg_write(1, d); reg_write(2, n);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(!m_valid && !irq && dgnt == '0, "R1 outputs idle", {m_valid, irq, dgnt}, 32'h0);
    for (int i = 0; i < 4; i++) expect_reg(i, 32'h0, "R1 register reset");
    // R2 / R11 / R10 register decode, count width, status write-1 ignored
    setup(32'h0000_1000, 32'h0000_2000, 32'h0123_4567);
    expect_reg(0, 32'h1000, "R2 source offset");
    expect_reg(1, 32'h2000, "R2 destination offset");
    expect_reg(2, 32'h0023_4567, "R11 count 24 bits");
    reg_write(3, 32'hFFFF_FFF0);
    expect_reg(3, 32'h0F3F_77E0, "R10 status set ignored, R2 reserved zero");
    reg_write(3, 32'h0);
    // R3/R4 word copy, +4 both sides, finish irq
    setup(32'h0000_1000, 32'h0000_2000, 32'd3);
    push_xfer(32'h1000, 32'h2000, 3'b011, 3'b011, 3, 3'b000);
    reg_write(3, 32'h0000_3305);
    idle(30);
    check(q_addr.size() == 0, "R3 all writes seen", q_addr.size(), 0);
    expect_reg(2, 32'h0, "R3 count exhausted");
    expect_reg(3, 32'h0000_3306, "R3 finish set, enable clear");
    check(irq === 1'b1, "R8 finish irq", irq, 1);
    reg_write(3, 32'h0000_3304);
    @(negedge clk);
    check(irq === 1'b0, "R10 status cleared drops irq", irq, 0);
    // R5 burst, halfword, src -2, dst fixed, dst on system bus, stalls
    setup(32'h0000_3000, 32'h0000_4000, 32'd2);
    push_xfer(32'h3000, 32'h4000, 3'b110, 3'b000, 8, 3'b101);
    stall_en = 1'b1;
    reg_write(3, 32'h0010_0689);
    idle(60);
    stall_en = 1'b0;
    check(q_addr.size() == 0, "R5 burst writes", q_addr.size(), 0);
    expect_reg(0, 32'h0000_2FF0, "R5 source moved 4x step per cycle");
    expect_reg(1, 32'h0000_4000, "R4 code 000 fixed");
    expect_reg(3, 32'h0010_068A, "R5 burst finish");
    check(irq === 1'b0, "R8 no irq without enable", irq, 0);
    reg_write(3, 32'h0);
    // R4 code 100 and +2, byte width
    setup(32'h0000_7003, 32'h0000_8001, 32'd4);
    push_xfer(32'h7003, 32'h8001, 3'b100, 3'b010, 4, 3'b010);
    reg_write(3, 32'h0020_2401);
    idle(30);
    check(q_addr.size() == 0, "R4 byte writes", q_addr.size(), 0);
    expect_reg(1, 32'h0000_8009, "R4 dst +2 per unit");
    expect_reg(0, 32'h0000_7003, "R4 code 100 no move");
    reg_write(3, 32'h0);
    // R7 handshake on destination line 3, R11 live count
    setup(32'h0000_9000, 32'h0000_A000, 32'd3);
    push_xfer(32'h9000, 32'hA000, 3'b011, 3'b011, 3, 3'b000);
    writes_seen = 0;
    reg_write(3, 32'h0003_3301);
    idle(10);
    check(writes_seen == 0, "R7 waits for request", writes_seen, 0);
    expect_reg(2, 32'd3, "R11 live count before request");
    @(negedge clk); dreq[3] = 1'b1;
    @(negedge clk); dreq[3] = 1'b0;
    idle(10);
    check(writes_seen == 1, "R7 one unit per request", writes_seen, 1);
    check(gnt3 == 1, "R7 one grant pulse", gnt3, 1);
    expect_reg(2, 32'd2, "R11 live count after one cycle");
    dreq[3] = 1'b1;
    idle(20);
    dreq[3] = 1'b0;
    check(gnt3 == 3 && gnt_other == 0, "R7 grants on line 3 only", gnt3, 3);
    expect_reg(3, 32'h0003_3302, "R7 handshake finish");
    reg_write(3, 32'h0);
    // R9 read-phase error
    setup(32'h0000_5000, 32'h0000_6000, 32'd2);
    err_on = 1'b1; err_addr = 32'h5000;
    reg_write(3, 32'h0000_3321);
    idle(10);
    expect_reg(3, 32'h0000_3330, "R9 read error stops");
    expect_reg(2, 32'd2, "R9 count unchanged");
    check(irq === 1'b1, "R8 error irq", irq, 1);
    reg_write(3, 32'h0000_3320);
    expect_reg(3, 32'h0000_3320, "R10 error cleared by 0");
    check(irq === 1'b0, "R8 irq drops", irq, 0);
    // R9 write-phase error
    setup(32'h0000_5000, 32'h0000_6000, 32'd1);
    err_addr = 32'h6000;
    reg_write(3, 32'h0000_3301);
    idle(10);
    expect_reg(3, 32'h0000_3310, "R9 write error stops");
    expect_reg(1, 32'h0000_6000, "R9 dst not advanced");
    expect_reg(0, 32'h0000_5004, "R9 src advanced by completed read");
    err_on = 1'b0;
    reg_write(3, 32'h0);
    // R3 zero count finishes at once
    writes_seen = 0;
    reg_write(2, 32'd0);
    reg_write(3, 32'h0000_0005);
    idle(5);
    expect_reg(3, 32'h0000_0006, "R3 zero count finish");
    check(writes_seen == 0 && !m_valid, "R3 no access on zero count", writes_seen, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule